// File: doc/BRIEF.md
# Clock-Control Register Slave

This block is the register front end of a clock-generation unit. It holds five 16-bit control and status words and one read-only 32-bit identification word. The words sit on a 4-byte address stride. A host issues single-cycle requests. Each request carries an address, a byte count and write data. The block answers one clock later with read data and an error flag.

Each word has its own access-width rule, and two words are read-only:

- The status word and the identifier keep their values when written.
- A legal write to either of them completes without an error.
- When a request breaks more than one rule, the width check is applied first.
- Reset loads fixed values into all five 16-bit words.
- The identifier value is set by a parameter.
- The oscillator, the lock detection and the lock-count timing live outside this block.

Top module: `clkreg_slave`

## Requirements
- R1: After reset the words read back as follows: offset 0x00 = 0xA800, 0x04 = 0x0004, 0x08 = 0x40FB, 0x0C = 0x00A2, 0x10 = 0x0300.
- R2: `resp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise. `rdata` and `resp_err` are zero whenever `resp_valid` is low.
- R3: A request whose `req_size` is neither 2 nor 4 returns `resp_err` = 1 at any address, including unmapped ones. It changes no state.
- R4: A request whose offset is not a multiple of 4, or is above 0x14, returns `resp_err` = 1 and changes no state.
- R5: A request with `req_size` = 4 to any of the five 16-bit words (offsets 0x00 to 0x10) returns `resp_err` = 1, whether it is a read or a write. It changes no state.
- R6: A 2-byte write to offset 0x00, 0x04, 0x08 or 0x10 stores `wdata[15:0]` and ignores `wdata[31:16]`. A 2-byte read returns the word zero-extended to 32 bits.
- R7: A 2-byte write to the status word (0x0C) completes with `resp_err` = 0 and leaves the word unchanged.
- R8: A 4-byte read at 0x14 returns the `CHIP_ID` parameter with no error. A 2-byte read at 0x14 returns `resp_err` = 1.
- R9: A write to 0x14 with `req_size` 2 or 4 completes with `resp_err` = 0 and leaves the identifier unchanged.
- R10: `rdata` is zero in every response that has `resp_err` = 1 and in every write response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the request |
| req_size | input | 3 | Byte count of the access |
| wdata | input | 32 | Write data; the 16-bit words use bits 15:0 |
| resp_valid | output | 1 | Response present, one cycle after the request |
| rdata | output | 32 | Read data, zero on a write or an error |
| resp_err | output | 1 | Illegal width, illegal offset or illegal width for the target word |

## Verification
A single request can break the width rule and the address map at the same time, for example a 1-byte or 3-byte access at an unmapped or misaligned offset. It can also break the width rule and hit a read-only word, for example a 4-byte write to the status word. The bench drives such combined cases from its vector table. It expects the error flag with zero data. It then reads the nearby writable words with legal requests, to show that the rejected access was dropped rather than partly applied. Two further collisions are checked the same way: a misaligned offset that would otherwise decode to a writable word, and a legal-width write to a read-only word.

// File: rtl/clkreg_pkg.sv
// Package: shared sizes and reset constants for the clock-control register slave.
// Assumes the 16-bit words occupy indices 0..NUM_HALF-1 and the identifier follows them.
package clkreg_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int HALF_W   = 16;
    localparam int NUM_HALF = 5;
    localparam int NUM_REG  = NUM_HALF + 1;
    localparam int ID_IDX   = NUM_HALF;
    localparam int STAT_IDX = 3;
    localparam int IDX_W    = $clog2(NUM_REG);
    localparam int OFS_W    = ADDR_W - 2;

    // One bit per 16-bit word: set when software may change it.
    localparam logic [NUM_HALF-1:0] WRITABLE = 5'b10111;

    // Reset value of each 16-bit word, by word index.
    function automatic logic [HALF_W-1:0] half_reset(input int idx);
        case (idx)
            0:       return 16'hA800;
            1:       return 16'h0004;
            2:       return 16'h40FB;
            3:       return 16'h00A2;
            default: return 16'h0300;
        endcase
    endfunction
endpackage

// File: rtl/clkreg_decode.sv
// Module: clkreg_decode
// Purely combinational check of one request against the width and address rules.
// Produces an error flag, the word index and a one-hot write enable.
// Assumes req_addr is a byte offset from the block base.
module clkreg_decode
    import clkreg_pkg::*;
(
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2:0]          req_size,
    output logic                dec_err,
    output logic [IDX_W-1:0]    dec_idx,
    output logic [NUM_HALF-1:0] dec_wr_en
);
    logic            size_ok;
    logic            wide;
    logic            mapped;
    logic [OFS_W-1:0] word;

    // Classify the access width and the offset.
    always_comb begin
        size_ok = (req_size == 3'd2) || (req_size == 3'd4);
        wide    = (req_size == 3'd4);
        word    = req_addr[ADDR_W-1:2];
        mapped  = (req_addr[1:0] == 2'b00) && (word < OFS_W'(NUM_REG));
    end

    // Apply the rules in priority order: width, then map, then the rule of each word.
    always_comb begin
        dec_err   = 1'b0;
        dec_wr_en = '0;
        dec_idx   = word[IDX_W-1:0];
        if (!size_ok) begin
            dec_err = 1'b1;
        end else if (!mapped) begin
            dec_err = 1'b1;
        end else if (word == OFS_W'(ID_IDX)) begin
            dec_err = !req_write && !wide;
        end else if (wide) begin
            dec_err = 1'b1;
        end else if (req_write) begin
            for (int i = 0; i < NUM_HALF; i++) begin
                if (word == OFS_W'(i) && WRITABLE[i])
                    dec_wr_en[i] = req_valid;
            end
        end
    end
endmodule

// File: rtl/clkreg_file.sv
// Module: clkreg_file
// Storage for the 16-bit words. Words that WRITABLE marks as writable take data on their enable.
// The others hold their reset value.
// Assumes at most one enable is high per cycle.
module clkreg_file
    import clkreg_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_HALF-1:0]            wr_en,
    input  logic [HALF_W-1:0]              wr_data,
    output logic [NUM_HALF-1:0][HALF_W-1:0] words
);
    for (genvar g = 0; g < NUM_HALF; g++) begin : g_word
        if (WRITABLE[g]) begin : g_rw
            // Writable word: reset value, then updated on its enable.
            always_ff @(posedge clk) begin
                if (!rst_n)        words[g] <= half_reset(g);
                else if (wr_en[g]) words[g] <= wr_data;
            end
        end else begin : g_ro
            // Read-only word: holds its reset value.
            always_ff @(posedge clk) begin
                words[g] <= half_reset(g);
            end
        end
    end

    // R6: the decoder never enables two words at once.
    p_single_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    // R7: the status word never changes once out of reset.
    p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> words[STAT_IDX] == half_reset(STAT_IDX));
endmodule

// File: rtl/clkreg_slave.sv
// Module: clkreg_slave
// Register slave of the clock-control unit. It accepts a request per cycle and answers one cycle later.
// Assumes the host holds no request open: every request is complete in one cycle.
module clkreg_slave
    import clkreg_pkg::*;
#(
    parameter logic [31:0] CHIP_ID = 32'h27C8_00CB
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic [2:0]  req_size,
    input  logic [31:0] wdata,
    output logic        resp_valid,
    output logic [31:0] rdata,
    output logic        resp_err
);
    logic                            dec_err;
    logic [IDX_W-1:0]                dec_idx;
    logic [NUM_HALF-1:0]             dec_wr_en;
    logic [NUM_HALF-1:0][HALF_W-1:0] words;
    logic [DATA_W-1:0]               rd_mux;

    clkreg_decode u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .dec_err   (dec_err),
        .dec_idx   (dec_idx),
        .dec_wr_en (dec_wr_en)
    );

    clkreg_file u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dec_wr_en),
        .wr_data (wdata[HALF_W-1:0]),
        .words   (words)
    );

    // Select read data: the identifier at full width, a 16-bit word zero-extended.
    always_comb begin
        rd_mux = '0;
        if (dec_idx == IDX_W'(ID_IDX))
            rd_mux = CHIP_ID;
        else if (dec_idx < IDX_W'(NUM_HALF))
            rd_mux = {{(DATA_W-HALF_W){1'b0}}, words[dec_idx]};
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_err   <= 1'b0;
            rdata      <= '0;
        end else begin
            resp_valid <= req_valid;
            resp_err   <= req_valid && dec_err;
            rdata      <= (req_valid && !dec_err && !req_write) ? rd_mux : '0;
        end
    end

    // R2: a response follows each request, and nothing else.
    p_resp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid && !resp_err && rdata == '0);

    // R3: an illegal width always reports an error.
    p_bad_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_size != 3'd2 && req_size != 3'd4 |=> resp_err);

    // R5: a 4-byte access to a 16-bit word is rejected.
    p_wide_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_size == 3'd4 && req_addr[1:0] == 2'b00 && req_addr < 8'h14 |=> resp_err);

    // R8: a 4-byte read of the identifier returns the parameter.
    p_id_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && req_addr == 8'h14 && req_size == 3'd4
        |=> !resp_err && rdata == CHIP_ID);

    // R10: an error or a write never carries data.
    p_err_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> rdata == '0);
endmodule

// File: tb/sim_clkreg_slave.sv
// Bench for clkreg_slave. A vector table is walked in order, then directed tests cover reset and idle.
module sim_clkreg_slave;
    localparam logic [31:0] CID = 32'h1234_5678;
    localparam int NV = 30;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [7:0]  req_addr;
    logic [2:0]  req_size;
    logic [31:0] wdata;
    logic        resp_valid, resp_err;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    clkreg_slave #(.CHIP_ID(CID)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .wdata(wdata),
        .resp_valid(resp_valid), .rdata(rdata), .resp_err(resp_err)
    );

    // Vector fields: {write, addr, size, wdata, expected err, expected rdata}.
    localparam logic [76:0] VEC [NV] = '{
        {1'b0, 8'h00, 3'd2, 32'h0,         1'b0, 32'h0000_A800}, // R1
        {1'b0, 8'h04, 3'd2, 32'h0,         1'b0, 32'h0000_0004}, // R1
        {1'b0, 8'h08, 3'd2, 32'h0,         1'b0, 32'h0000_40FB}, // R1
        {1'b0, 8'h0C, 3'd2, 32'h0,         1'b0, 32'h0000_00A2}, // R1
        {1'b0, 8'h10, 3'd2, 32'h0,         1'b0, 32'h0000_0300}, // R1
        {1'b0, 8'h14, 3'd4, 32'h0,         1'b0, CID},           // R8
        {1'b1, 8'h00, 3'd2, 32'hFFFF_1234, 1'b0, 32'h0},         // R6 R10
        {1'b0, 8'h00, 3'd2, 32'h0,         1'b0, 32'h0000_1234}, // R6
        {1'b1, 8'h0C, 3'd2, 32'h0000_5555, 1'b0, 32'h0},         // R7
        {1'b0, 8'h0C, 3'd2, 32'h0,         1'b0, 32'h0000_00A2}, // R7
        {1'b1, 8'h0C, 3'd4, 32'h0000_5555, 1'b1, 32'h0},         // R5 R7
        {1'b1, 8'h04, 3'd4, 32'h0000_0009, 1'b1, 32'h0},         // R5
        {1'b0, 8'h04, 3'd2, 32'h0,         1'b0, 32'h0000_0004}, // R5
        {1'b0, 8'h08, 3'd4, 32'h0,         1'b1, 32'h0},         // R5 R10
        {1'b1, 8'h14, 3'd4, 32'hDEAD_BEEF, 1'b0, 32'h0},         // R9
        {1'b1, 8'h14, 3'd2, 32'h0000_BEEF, 1'b0, 32'h0},         // R9
        {1'b0, 8'h14, 3'd4, 32'h0,         1'b0, CID},           // R9
        {1'b0, 8'h14, 3'd2, 32'h0,         1'b1, 32'h0},         // R8
        {1'b0, 8'h18, 3'd2, 32'h0,         1'b1, 32'h0},         // R4
        {1'b1, 8'h02, 3'd2, 32'h0000_0007, 1'b1, 32'h0},         // R4
        {1'b0, 8'h00, 3'd2, 32'h0,         1'b0, 32'h0000_1234}, // R4
        {1'b1, 8'h40, 3'd3, 32'h0000_0001, 1'b1, 32'h0},         // R3
        {1'b0, 8'h1A, 3'd1, 32'h0,         1'b1, 32'h0},         // R3
        {1'b1, 8'h10, 3'd1, 32'h0000_0000, 1'b1, 32'h0},         // R3
        {1'b0, 8'h10, 3'd2, 32'h0,         1'b0, 32'h0000_0300}, // R3
        {1'b1, 8'h08, 3'd2, 32'h5A5A_ABCD, 1'b0, 32'h0},         // R6
        {1'b0, 8'h08, 3'd2, 32'h0,         1'b0, 32'h0000_ABCD}, // R6
        {1'b1, 8'h10, 3'd2, 32'h0000_0042, 1'b0, 32'h0},         // R6
        {1'b0, 8'h10, 3'd2, 32'h0,         1'b0, 32'h0000_0042}, // R6
        {1'b0, 8'hFF, 3'd0, 32'h0,         1'b1, 32'h0}          // R3
    };

    // Compare one response and count the check.
    task automatic check(input string tag, input logic v, input logic e, input logic [31:0] d,
                         input logic ev, input logic ee, input logic [31:0] ed);
        n_chk++;
        if (v !== ev || e !== ee || d !== ed) begin
            n_bad++;
            $display("FAIL %s: valid/err/rdata = %0b/%0b/%h, expected %0b/%0b/%h",
                     tag, v, e, d, ev, ee, ed);
        end
    endtask

    // Issue one request at a falling edge and compare the response one cycle later.
    task automatic access(input string tag, input logic w, input logic [7:0] a, input logic [2:0] s,
                          input logic [31:0] wd, input logic ee, input logic [31:0] ed);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, resp_valid, resp_err, rdata, 1'b1, ee, ed);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_size = '0; wdata = '0;
        repeat (3) @(negedge clk);
        // R2: response outputs idle and zero during reset.
        check("R2 reset idle", resp_valid, resp_err, rdata, 1'b0, 1'b0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            access($sformatf("vector %0d", i), VEC[i][76], VEC[i][75:68], VEC[i][67:65],
                   VEC[i][64:33], VEC[i][32], VEC[i][31:0]);
        end

        // R2: an idle cycle after a request gives no response.
        @(negedge clk);
        check("R2 idle", resp_valid, resp_err, rdata, 1'b0, 1'b0, 32'h0);

        // R1: reset restores the written words.
        access("R1 pre-reset write", 1'b1, 8'h04, 3'd2, 32'h0000_7777, 1'b0, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access("R1 reset divider", 1'b0, 8'h04, 3'd2, 32'h0, 1'b0, 32'h0000_0004);
        access("R1 reset control", 1'b0, 8'h00, 3'd2, 32'h0, 1'b0, 32'h0000_A800);
        access("R1 reset lock count", 1'b0, 8'h10, 3'd2, 32'h0, 1'b0, 32'h0000_0300);
        access("R1 reset regulator", 1'b0, 8'h08, 3'd2, 32'h0, 1'b0, 32'h0000_40FB);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule